// File: doc/BRIEF.md
# Beat and Transport Pulse Generator

This block converts a software-maintained tempo grid into physical timing signals. A free-running microsecond count and a one-cycle 1 MHz tick enable arrive from outside. Software programs a beat period and the absolute microsecond time of the next beat. Hardware then places every beat, the 96, 48 and 24 pulses-per-quarter-note subdivisions and the bar pulse on exact microsecond ticks, without software on the timing path. After each beat the target advances by one period. A new target write replaces the running one.

Transport is driven by three strobes: play, stop and resync. A play request arms the transport. The run level and a one-shot start pulse then appear on the next beat edge, which is always the first beat of a bar. A stop request drops the run level at once and emits a one-shot stop pulse. A resync request makes the next beat a bar start. Each pulse output is stretched to a programmable number of microsecond ticks. After reset the defaults are a 1000-tick pulse width, 4 beats per bar and a 500000 µs period.

Top module: `beat_pulse_gen`

## Requirements
- R1: After reset every pulse output and the run output are low.
- R2: A beat occurs on a tick at which the microsecond input equals the target register. The target then advances by the period. A write with select code 1 replaces the target. Select code 0 writes the period, 2 the pulse width and 3 the beats per bar.
- R3: While running, a beat at time T with period P (P at least 96) produces 96-PPQN pulses at T + floor(k*P/96) for k = 0..95, so the pulse for k = 96 coincides with the next beat.
- R4: The 48-PPQN output fires on the subdivisions with even k and the 24-PPQN output on those with k a multiple of 4. Both include the beat itself.
- R5: The bar output fires together with a beat whose index within the bar is 0. The index wraps at the beats-per-bar value.
- R6: A play request while stopped arms the transport. The start pulse, the rise of the run output and a bar pulse all occur on the next beat. A play request while running has no effect.
- R7: A stop request while running drops the run output and fires the stop pulse at that tick, and it cancels any subdivisions still due in that beat, including one due on the same tick. A stop request while stopped produces no pulse.
- R8: While stopped, beats still advance the target but produce no pulses on any output.
- R9: Each pulse output stays high for exactly the programmed width in ticks, counted from its firing tick.
- R10: A resync request cancels the remaining subdivisions of the current beat and makes the next beat index 0, so it fires a bar pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| now_us | input | 32 | Current microsecond count, valid on tick cycles |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 target, 2 width, 3 beats per bar |
| wr_data | input | 32 | Register write data |
| play_req | input | 1 | Arm transport start |
| stop_req | input | 1 | Stop transport |
| resync_req | input | 1 | Make the next beat a bar start |
| clk96_o | output | 1 | 96-PPQN pulse |
| clk48_o | output | 1 | 48-PPQN pulse |
| clk24_o | output | 1 | 24-PPQN pulse |
| beat_o | output | 1 | Beat pulse |
| bar_o | output | 1 | Bar pulse |
| start_o | output | 1 | Start one-shot |
| stop_o | output | 1 | Stop one-shot |
| run_o | output | 1 | High while playing |

## Verification
Assertions check on every cycle the following properties. The run level rises only on a beat hit and falls after a stop. No pulse is fired while stopped. The remainder accumulator and the subdivision index stay in range. A fired pulse is high on the following cycle. A bar never rises without a beat. Only the bench's scenarios can show the following. Subdivision times follow floor(k*P/96) with a nonzero remainder. Bar placement follows the beats-per-bar value and resync. The measured pulse widths match the programmed values. Stray play and stop requests leave the outputs quiet.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int SUBS = 96;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_TARGET = 2'd1,
    SEL_WIDTH  = 2'd2,
    SEL_BPB    = 2'd3
  } reg_sel_e;

  // extra tick owed by this subdivision step (Bresenham carry)
  function automatic logic step_carry(input logic [6:0] acc, input logic [6:0] rem);
    logic [7:0] s;
    s = {1'b0, acc} + {1'b0, rem};
    return (s >= 8'(SUBS));
  endfunction

  function automatic logic [6:0] acc_next(input logic [6:0] acc, input logic [6:0] rem);
    logic [7:0] s;
    s = {1'b0, acc} + {1'b0, rem};
    return (s >= 8'(SUBS)) ? 7'(s - 8'(SUBS)) : 7'(s);
  endfunction
endpackage

// File: rtl/bpg_subdiv.sv
module bpg_subdiv
  import bpg_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          beat_ev,
  input  logic          cancel,
  input  logic [PW-1:0] period,
  output logic          sub_ev,
  output logic          sub_even,
  output logic          sub_quad
);
  logic [PW-1:0] quo_w, quo_q, cnt_q;
  logic [6:0]    rem_w, rem_q, acc_q, k_q, k_fire;
  logic          active_q;

  assign quo_w    = period / PW'(SUBS);
  assign rem_w    = 7'(period % PW'(SUBS));
  assign sub_ev   = tick && active_q && (cnt_q == PW'(1)) && !cancel;
  assign k_fire   = k_q + 7'd1;
  assign sub_even = !k_fire[0];
  assign sub_quad = (k_fire[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      quo_q    <= '0;
      rem_q    <= '0;
      acc_q    <= '0;
      k_q      <= '0;
      cnt_q    <= '0;
    end else if (beat_ev) begin
      active_q <= 1'b1;
      k_q      <= '0;
      quo_q    <= quo_w;
      rem_q    <= rem_w;
      cnt_q    <= quo_w + PW'(step_carry(7'd0, rem_w));
      acc_q    <= acc_next(7'd0, rem_w);
    end else if (cancel) begin
      active_q <= 1'b0;
    end else if (tick && active_q) begin
      if (cnt_q == PW'(1)) begin
        k_q <= k_fire;
        if (k_q == 7'd94) begin
          active_q <= 1'b0;
        end else begin
          cnt_q <= quo_q + PW'(step_carry(acc_q, rem_q));
          acc_q <= acc_next(acc_q, rem_q);
        end
      end else begin
        cnt_q <= cnt_q - PW'(1);
      end
    end
  end

  AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ev |-> (k_q < 7'd95)); // R3
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (acc_q < 7'd96)); // R3
  AST_STOP_AFTER_95: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_ev && k_q == 7'd94 && !beat_ev) |=> !active_q); // R3
endmodule

// File: rtl/bpg_stretch.sv
module bpg_stretch #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fire,
  input  logic [WW-1:0] width,
  output logic          pulse
);
  logic [WW-1:0] cnt_q;

  assign pulse = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (fire)             cnt_q <= width;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - WW'(1);
  end

  AST_FIRE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && width != '0) |=> pulse); // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !tick) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/beat_pulse_gen.sv
module beat_pulse_gen
  import bpg_pkg::*;
#(
  parameter int TW          = 32,
  parameter int PW          = 24,
  parameter int WW          = 16,
  parameter int BW          = 4,
  parameter int DEF_PERIOD  = 500000,
  parameter int DEF_WIDTH   = 1000,
  parameter int DEF_BPB     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic [TW-1:0] now_us,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          play_req,
  input  logic          stop_req,
  input  logic          resync_req,
  output logic          clk96_o,
  output logic          clk48_o,
  output logic          clk24_o,
  output logic          beat_o,
  output logic          bar_o,
  output logic          start_o,
  output logic          stop_o,
  output logic          run_o
);
  localparam int NOUT = 7;

  logic [PW-1:0] period_q;
  logic [TW-1:0] tgt_q;
  logic [WW-1:0] width_q;
  logic [BW-1:0] bpb_q, bidx_q, cur_idx, idx_inc;
  logic          run_q, armed_q, resync_q;

  // named internal events
  logic beat_hit, start_ev, stop_ev, beat_ev, bar_ev;
  logic sub_ev, sub_even, sub_quad;
  logic [NOUT-1:0] fire_vec, pulse_vec;

  assign beat_hit = tick_us && (now_us == tgt_q);
  assign start_ev = beat_hit && armed_q && !run_q && !stop_req;
  assign stop_ev  = stop_req && run_q;
  assign beat_ev  = beat_hit && ((run_q && !stop_req) || start_ev);
  assign cur_idx  = (start_ev || resync_q) ? '0 : bidx_q;
  assign idx_inc  = cur_idx + BW'(1);
  assign bar_ev   = beat_ev && (cur_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PW'(DEF_PERIOD);
      width_q  <= WW'(DEF_WIDTH);
      bpb_q    <= BW'(DEF_BPB);
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_PERIOD: period_q <= wr_data[PW-1:0];
        SEL_WIDTH:  width_q  <= wr_data[WW-1:0];
        SEL_BPB:    bpb_q    <= wr_data[BW-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                        tgt_q <= '0;
    else if (wr_en && reg_sel_e'(wr_sel) == SEL_TARGET) tgt_q <= wr_data;
    else if (beat_hit)                                 tgt_q <= tgt_q + TW'(period_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      resync_q <= 1'b0;
      bidx_q   <= '0;
    end else begin
      if (stop_ev)       run_q <= 1'b0;
      else if (start_ev) run_q <= 1'b1;

      if (stop_req || start_ev)  armed_q <= 1'b0;
      else if (play_req && !run_q) armed_q <= 1'b1;

      if (resync_req)   resync_q <= 1'b1;
      else if (beat_ev) resync_q <= 1'b0;

      if (beat_ev) bidx_q <= (idx_inc >= bpb_q) ? '0 : idx_inc;
    end
  end

  bpg_subdiv #(.PW(PW)) u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .beat_ev  (beat_ev),
    .cancel   (stop_ev || resync_req),
    .period   (period_q),
    .sub_ev   (sub_ev),
    .sub_even (sub_even),
    .sub_quad (sub_quad)
  );

  assign fire_vec[0] = beat_ev || sub_ev;
  assign fire_vec[1] = beat_ev || (sub_ev && sub_even);
  assign fire_vec[2] = beat_ev || (sub_ev && sub_quad);
  assign fire_vec[3] = beat_ev;
  assign fire_vec[4] = bar_ev;
  assign fire_vec[5] = start_ev;
  assign fire_vec[6] = stop_ev;

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    bpg_stretch #(.WW(WW)) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_us),
      .fire  (fire_vec[i]),
      .width (width_q),
      .pulse (pulse_vec[i])
    );
  end

  assign clk96_o = pulse_vec[0];
  assign clk48_o = pulse_vec[1];
  assign clk24_o = pulse_vec[2];
  assign beat_o  = pulse_vec[3];
  assign bar_o   = pulse_vec[4];
  assign start_o = pulse_vec[5];
  assign stop_o  = pulse_vec[6];
  assign run_o   = run_q;

  AST_START_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(beat_hit)); // R6
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !run_q); // R7
  AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_ev) |-> (fire_vec[4:0] == '0)); // R8
  AST_BEAT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_o) |-> $past(beat_hit)); // R2
  AST_BAR_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_o) |-> beat_o); // R5
endmodule

// File: tb/sim_beat_pulse_gen.sv
module sim_beat_pulse_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, tick_us, wr_en, play_req, stop_req, resync_req;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, now_us;
  logic clk96_o, clk48_o, clk24_o, beat_o, bar_o, start_o, stop_o, run_o;

  beat_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .now_us(now_us),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .play_req(play_req), .stop_req(stop_req), .resync_req(resync_req),
    .clk96_o(clk96_o), .clk48_o(clk48_o), .clk24_o(clk24_o),
    .beat_o(beat_o), .bar_o(bar_o), .start_o(start_o), .stop_o(stop_o),
    .run_o(run_o)
  );

  typedef struct {
    int unsigned t;
    int          kind;
    int unsigned data;
  } cmd_t;

  cmd_t        cmds[$];
  int unsigned expq[8][$];
  int unsigned now_t;
  int          checks = 0, fails = 0;
  int unsigned exp_w, w_at_rise, rise_beat;
  logic [7:0]  prev;
  bit          done = 0;

  assign now_us = now_t;

  function automatic string req_of(input int id);
    case (id)
      0:       return "R3";
      1, 2:    return "R4";
      3:       return "R2";
      4:       return "R5/R10";
      5, 7:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sched(input int unsigned t, input int kind, input int unsigned data);
    cmd_t c;
    c.t = t; c.kind = kind; c.data = data;
    cmds.push_back(c);
  endtask

  task automatic expect_ev(input int id, input int unsigned t);
    expq[id].push_back(t);
  endtask

  // driver: expected edges of one beat, subdivision k at T + floor(k*P/96)
  task automatic push_beat(input int unsigned T, input int unsigned P, input int kmax,
                           input bit bar, input bit start);
    for (int k = 0; k <= kmax; k++) begin
      int unsigned t;
      t = T + (k * P) / 96;
      expect_ev(0, t);                 // R3
      if (k % 2 == 0) expect_ev(1, t); // R4
      if (k % 4 == 0) expect_ev(2, t); // R4
    end
    expect_ev(3, T);                   // R2
    if (bar) expect_ev(4, T);          // R5
    if (start) begin
      expect_ev(5, T);                 // R6
      expect_ev(7, T);
    end
  endtask

  // monitor: pop and compare each rising edge against the scoreboard
  task automatic monitor();
    logic [7:0] cur;
    cur = {run_o, stop_o, start_o, bar_o, beat_o, clk24_o, clk48_o, clk96_o};
    for (int i = 0; i < 8; i++) begin
      if (cur[i] && !prev[i]) begin
        if (expq[i].size() == 0) begin
          chk(0, (i == 5 || i == 7) ? "R6" : (i == 6 ? "R7" : "R8"),
              $sformatf("unexpected edge on output %0d", i), now_t, 0);
        end else begin
          int unsigned e;
          e = expq[i].pop_front();
          chk(e == now_t, req_of(i), $sformatf("edge time output %0d", i), now_t, e);
        end
      end
    end
    if (cur[3] && !prev[3]) begin
      rise_beat = now_t;
      w_at_rise = exp_w;
    end
    if (!cur[3] && prev[3])
      chk((now_t - rise_beat) == w_at_rise, "R9", "beat pulse width", now_t - rise_beat, w_at_rise);
    prev = cur;
  endtask

  task automatic drive();
    if (!tick_us) begin
      tick_us = 1'b1;
      now_t++;
      while (cmds.size() != 0 && cmds[0].t == now_t) begin
        cmd_t c;
        c = cmds.pop_front();
        if (c.kind <= 3) begin
          wr_en   = 1'b1;
          wr_sel  = 2'(c.kind);
          wr_data = c.data;
          if (c.kind == 2) exp_w = c.data;
        end
        if (c.kind == 4) play_req   = 1'b1;
        if (c.kind == 5) stop_req   = 1'b1;
        if (c.kind == 6) resync_req = 1'b1;
      end
    end else begin
      tick_us = 1'b0; wr_en = 1'b0;
      play_req = 1'b0; stop_req = 1'b0; resync_req = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "R2", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_us = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    play_req = 1'b0; stop_req = 1'b0; resync_req = 1'b0;
    now_t = 0; exp_w = 1000; prev = '0;

    // scenario A: period 960 (no remainder), width 3, 4 beats per bar
    sched(5, 0, 960);
    sched(6, 2, 3);
    sched(20, 1, 50);
    sched(30, 4, 0);
    for (int b = 0; b < 4; b++) push_beat(50 + b * 960, 960, 95, b == 0, b == 0);
    push_beat(3890, 960, 10, 1, 0);       // R5 wrap at 4; R7 sub due at 4000 cancelled
    expect_ev(6, 4000);                   // R7 stop pulse
    // scenario B: period 1000 (remainder 40), 2 beats per bar, width 5
    sched(4000, 5, 0);
    sched(4100, 0, 1000);
    sched(4120, 3, 2);
    sched(4150, 2, 5);
    sched(4200, 4, 0);
    sched(4300, 1, 5000);
    sched(5500, 4, 0);                    // R6 play while running ignored
    push_beat(5000, 1000, 95, 1, 1);
    push_beat(6000, 1000, 95, 0, 0);
    push_beat(7000, 1000, 28, 1, 0);      // R10 resync at 7300 cancels k>=29
    sched(7300, 6, 0);
    push_beat(8000, 1000, 95, 1, 0);      // R10 bar forced on what would be index 1
    push_beat(9000, 1000, 43, 0, 0);
    sched(9450, 5, 0);
    expect_ev(6, 9450);                   // R7
    sched(9800, 5, 0);                    // R7 stop while stopped: no pulse; R8 beat at 10000 quiet

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({run_o, stop_o, start_o, bar_o, beat_o, clk24_o, clk48_o, clk96_o} == 8'h00,
        "R1", "outputs after reset", {run_o, stop_o, start_o, bar_o, beat_o, clk24_o, clk48_o, clk96_o}, 0);

    while (now_t < 10300) begin
      @(negedge clk);
      monitor();
      drive();
    end

    for (int i = 0; i < 8; i++)
      chk(expq[i].size() == 0, req_of(i), $sformatf("missing edges output %0d", i), expq[i].size(), 0);
    chk(run_o == 1'b0, "R7", "run level after stop", run_o, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule